// File: doc/BRIEF.md
# Row-Wrapping I2C Register Target

This block is an I2C-compatible target that gives a controller byte access to a 256-location register space. SCL and SDA are oversampled in the system clock domain. The block drives SDA through an open-drain enable, so `sda_oe` high pulls the line low. It answers the 7-bit address `110000` followed by the level of `addr_pin`. The first byte after the address in a write loads an internal pointer. Each further byte is handed to the register file through a one-cycle write strobe, and the pointer then steps within its aligned row.

Reads start at the current pointer and step through the whole space. Each byte is fetched through a one-cycle read strobe. The register file must present `reg_rdata` for `reg_addr` in the same cycle as `reg_rd`.

A write that touches the nonvolatile window (`NV_FIRST`..`NV_LAST`, by default 10h..3Bh) arms a programming interval, which begins at the following STOP. For `BUSY_CYCLES` clocks the block raises `nv_busy` and refuses its own address, so a controller can poll for completion.

Top module: `rowpage_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `110000` followed by `addr_pin`, pulling SDA low during the 9th clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read. With `addr_pin` low, C0h and C1h are acknowledged.
- R2: After an address byte that does not match, the target gives no acknowledge and issues no register strobe until the next START.
- R3: In a write, the byte after the address byte loads the pointer and is not stored. Each later byte produces one `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. Each such byte is acknowledged.
- R4: After each stored byte, the write pointer steps by one within its aligned row of `ROW_BYTES` (default 8). From the last location of the row it returns to the row base.
- R5: A read with no preceding pointer byte starts at the current pointer. A pointer write followed by a repeated START sets the read start. Read addresses step by one modulo 256 and do not wrap within a row.
- R6: During a read, a controller ACK causes the next byte to be fetched and sent. A controller NACK ends the read: SDA stays released and no further `reg_rd` is issued until a new START.
- R7: Bits are shifted in on SCL rising edges, MSB first. The target changes `sda_oe` only while SCL is low.
- R8: A STOP that ends a write which stored any byte in the nonvolatile window raises `nv_busy` for exactly `BUSY_CYCLES` clocks. While it is high, the target does not acknowledge its own address and issues no strobe. A write touching only locations outside the window leaves `nv_busy` low.
- R9: After reset, `sda_oe`, `nv_busy`, `reg_wr` and `reg_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin | input | 1 | Strapped low bit of the target address |
| sda_oe | output | 1 | High pulls SDA low |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register address for either strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rdata | input | 8 | Read data, valid in the cycle of `reg_rd` |
| nv_busy | output | 1 | Programming interval in progress |

## Verification
The assertions assume that each SCL high and low phase lasts longer than the synchroniser depth plus two clocks. This way, a change of `sda_oe` made after a sensed falling edge still lands while the raw SCL is low. They also assume that the controller moves SDA during SCL high only to form START or STOP, and never while the target is driving. The stimulus holds every SCL quarter period for eight clocks and changes controller SDA only in the low phase, except inside its START and STOP sequences. It issues STOP and repeated START only after the target has released the line.

// File: rtl/rowpage_pkg.sv
package rowpage_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_MEM, PH_WR, PH_RD} phase_t;
endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   // stage k holds {scl,sda} after k+1 flops; the last stage is the one-cycle-old copy
   logic [SYNC_STAGES:0][1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[SYNC_STAGES-1:0], {scl_i, sda_i}};
   end

   logic scl_q, sda_q;
   assign scl_s    = stg[SYNC_STAGES-1][1];
   assign sda_s    = stg[SYNC_STAGES-1][0];
   assign scl_q    = stg[SYNC_STAGES][1];
   assign sda_q    = stg[SYNC_STAGES][0];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/nv_hold_timer.sv
module nv_hold_timer #(
   parameter int unsigned BUSY_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic busy
);
   if (BUSY_CYCLES == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_count
      localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
      localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (arm)        cnt <= LOAD;
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
   end
endmodule

// File: rtl/i2c_row_engine.sv
module i2c_row_engine
   import rowpage_pkg::*;
#(
   parameter int unsigned ROW_BYTES = 8,
   parameter logic [7:0]  NV_FIRST  = 8'h10,
   parameter logic [7:0]  NV_LAST   = 8'h3B,
   parameter logic [5:0]  DEV_HI    = 6'b110000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sda_s,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_ev,
   input  logic  stop_ev,
   input  logic  addr_pin,
   input  logic  busy,
   input  byte_t reg_rdata,
   output logic  sda_drv,
   output logic  reg_wr,
   output logic  reg_rd,
   output byte_t reg_addr,
   output byte_t reg_wdata,
   output logic  nv_done
);
   localparam int unsigned ROW_W = $clog2(ROW_BYTES);
   localparam logic [3:0]  BITS  = 4'd8;

   phase_t     ph;
   logic       in_ack, rd_dir, host_nack, nv_dirty, load_pend;
   logic [3:0] bitcnt;
   byte_t      shreg, tx, ptr, ptr_row_next;

   always_comb begin
      ptr_row_next = ptr;
      ptr_row_next[ROW_W-1:0] = ptr[ROW_W-1:0] + 1'b1;
   end

   function automatic logic in_nv(input byte_t a);
      return (a >= NV_FIRST) && (a <= NV_LAST);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE; in_ack <= 1'b0; rd_dir <= 1'b0; host_nack <= 1'b0;
         nv_dirty <= 1'b0; load_pend <= 1'b0; bitcnt <= '0;
         shreg <= '0; tx <= '0; ptr <= '0; sda_drv <= 1'b0;
         reg_wr <= 1'b0; reg_rd <= 1'b0; reg_addr <= '0; reg_wdata <= '0; nv_done <= 1'b0;
      end else begin
         reg_wr  <= 1'b0;
         reg_rd  <= 1'b0;
         nv_done <= 1'b0;
         if (load_pend) begin
            tx        <= reg_rdata;
            ptr       <= ptr + 1'b1;
            load_pend <= 1'b0;
         end
         if (start_ev) begin
            ph <= PH_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_drv <= 1'b0;
         end else if (stop_ev) begin
            ph <= PH_IDLE; in_ack <= 1'b0; sda_drv <= 1'b0;
            nv_done  <= nv_dirty;
            nv_dirty <= 1'b0;
         end else if (ph != PH_IDLE) begin
            if (!in_ack) begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == BITS) begin
                  bitcnt <= '0;
                  in_ack <= 1'b1;
                  case (ph)
                     PH_DEV: begin
                        if (shreg[7:1] == {DEV_HI, addr_pin} && !busy) begin
                           sda_drv <= 1'b1;
                           rd_dir  <= shreg[0];
                           if (shreg[0]) begin
                              reg_rd <= 1'b1; reg_addr <= ptr; load_pend <= 1'b1;
                           end
                        end else begin
                           ph <= PH_IDLE; in_ack <= 1'b0;
                        end
                     end
                     PH_MEM: begin
                        ptr <= shreg; sda_drv <= 1'b1;
                     end
                     PH_WR: begin
                        reg_wr <= 1'b1; reg_addr <= ptr; reg_wdata <= shreg;
                        ptr <= ptr_row_next; sda_drv <= 1'b1;
                        if (in_nv(ptr)) nv_dirty <= 1'b1;
                     end
                     default: sda_drv <= 1'b0;
                  endcase
               end else if (scl_fall && ph == PH_RD && bitcnt != '0) begin
                  sda_drv <= ~tx[3'd7 - bitcnt[2:0]];
               end
            end else begin
               if (scl_rise && ph == PH_RD) begin
                  host_nack <= sda_s;
                  if (!sda_s) begin
                     reg_rd <= 1'b1; reg_addr <= ptr; load_pend <= 1'b1;
                  end
               end else if (scl_fall) begin
                  in_ack <= 1'b0;
                  case (ph)
                     PH_DEV: begin
                        if (rd_dir) begin ph <= PH_RD; sda_drv <= ~tx[7]; end
                        else begin ph <= PH_MEM; sda_drv <= 1'b0; end
                     end
                     PH_MEM: begin ph <= PH_WR; sda_drv <= 1'b0; end
                     PH_RD: begin
                        if (host_nack) begin ph <= PH_IDLE; sda_drv <= 1'b0; end
                        else sda_drv <= ~tx[7];
                     end
                     default: sda_drv <= 1'b0;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/rowpage_i2c_target.sv
module rowpage_i2c_target
   import rowpage_pkg::*;
#(
   parameter int unsigned ROW_BYTES   = 8,
   parameter logic [7:0]  NV_FIRST    = 8'h10,
   parameter logic [7:0]  NV_LAST     = 8'h3B,
   parameter logic [5:0]  DEV_HI      = 6'b110000,
   parameter int unsigned BUSY_CYCLES = 2000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_pin,
   output logic       sda_oe,
   output logic       reg_wr,
   output logic       reg_rd,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata,
   output logic       nv_busy
);
   if (ROW_BYTES < 2 || ROW_BYTES > 256 || (ROW_BYTES & (ROW_BYTES - 1)) != 0) begin : g_bad_row
      $error("ROW_BYTES must be a power of two from 2 to 256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NV_FIRST > NV_LAST) begin : g_bad_nv
      $error("NV_FIRST must not exceed NV_LAST");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, nv_done;

   i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   i2c_row_engine #(
      .ROW_BYTES(ROW_BYTES), .NV_FIRST(NV_FIRST), .NV_LAST(NV_LAST), .DEV_HI(DEV_HI)
   ) engine_i (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .addr_pin(addr_pin), .busy(nv_busy),
      .reg_rdata(reg_rdata), .sda_drv(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .nv_done(nv_done)
   );

   nv_hold_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .arm(nv_done), .busy(nv_busy)
   );

   logic unused_scl_s;
   assign unused_scl_s = scl_s;
endmodule

// File: rtl/rowpage_i2c_target_chk.sv
module rowpage_i2c_target_chk #(
   parameter int unsigned ROW_BYTES   = 8,
   parameter int unsigned BUSY_CYCLES = 2000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [7:0] reg_addr,
   input logic       nv_busy,
   input logic       start_ev
);
   localparam int unsigned RW = $clog2(ROW_BYTES);

   logic       prev_ok;
   logic [7:0] prev_addr, succ;
   int unsigned run;

   always_comb begin
      succ = prev_addr;
      succ[RW-1:0] = prev_addr[RW-1:0] + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ok <= 1'b0; prev_addr <= '0; run <= 0;
      end else begin
         if (start_ev)    prev_ok <= 1'b0;
         else if (reg_wr) begin prev_ok <= 1'b1; prev_addr <= reg_addr; end
         run <= nv_busy ? run + 1 : 0;
      end
   end

   // R7: the data line is only moved while the bus clock is low
   a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R4: consecutive stores in one transaction stay in the row and step by one
   a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && prev_ok) |-> (reg_addr == succ));

   // R3: never a read and a write strobe together
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr, reg_rd}));

   // R8: busy lasts exactly the programmed interval
   a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_busy) |-> (run == BUSY_CYCLES));

   // R8: no register traffic is accepted while busy
   a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |-> (!reg_wr && !reg_rd));
endmodule

bind rowpage_i2c_target rowpage_i2c_target_chk #(
   .ROW_BYTES(ROW_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .nv_busy(nv_busy), .start_ev(start_ev)
);

// File: tb/rowpage_i2c_target_tb.sv
module rowpage_i2c_target_tb_top;
   localparam int BUSY = 600;
   localparam int Q    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_c = 1'b1, sda_c = 1'b1, addr_pin = 1'b0;
   logic sda_oe, reg_wr, reg_rd, nv_busy;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic sda_line;

   always #2 clk = ~clk;
   assign sda_line = sda_c & ~sda_oe;

   rowpage_i2c_target #(.BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_line), .addr_pin(addr_pin),
      .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nv_busy(nv_busy)
   );

   // register file and logs owned by the bench
   logic [7:0] mem [256];
   logic [7:0] shadow [256];
   logic [7:0] wl_addr [512];
   logic [7:0] wl_data [512];
   int wn = 0, rn = 0, busy_len = 0, viol = 0;
   logic prev_oe = 1'b0;
   assign reg_rdata = mem[reg_addr];

   initial for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
   end

   always @(posedge clk) begin
      if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
         wl_addr[wn] <= reg_addr;
         wl_data[wn] <= reg_wdata;
         wn <= wn + 1;
      end
      if (reg_rd) rn <= rn + 1;
      if (nv_busy) busy_len <= busy_len + 1;
      if (rst_n && sda_oe != prev_oe && scl_c) viol <= viol + 1;
      prev_oe <= sda_oe;
   end

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_c = 1'b1; w(Q); scl_c = 1'b1; w(Q); sda_c = 1'b0; w(Q); scl_c = 1'b0; w(Q);
   endtask

   task automatic i2c_stop();
      sda_c = 1'b0; w(Q); scl_c = 1'b1; w(Q); sda_c = 1'b1; w(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         scl_c = 1'b0; w(Q); sda_c = b[i]; w(Q); scl_c = 1'b1; w(2 * Q);
      end
      scl_c = 1'b0; w(Q); sda_c = 1'b1; w(Q); scl_c = 1'b1; w(Q);
      ack = ~sda_line; w(Q); scl_c = 1'b0;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      sda_c = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         scl_c = 1'b0; w(2 * Q); scl_c = 1'b1; w(Q); b[i] = sda_line; w(Q);
      end
      scl_c = 1'b0; w(Q); sda_c = nack; w(Q); scl_c = 1'b1; w(2 * Q);
      scl_c = 1'b0; w(Q); sda_c = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] rb;
      int base, rbase;
      w(10); rst_n = 1'b1; w(3);
      // R9: reset state
      chk(!sda_oe && !nv_busy && !reg_wr && !reg_rd, "R9 reset outputs",
          {sda_oe, nv_busy, reg_wr, reg_rd}, 0);

      // R1/R2: address sweep, write direction, addr_pin low
      base = wn; rbase = rn;
      for (int a = 0; a < 128; a++) begin
         i2c_start(); send_byte({7'(a), 1'b0}, ack); i2c_stop();
         chk(ack == (a == 7'h60), "R1 address match", ack, (a == 7'h60));
      end
      chk(wn == base && rn == rbase, "R2 no strobes in sweep", wn - base + rn - rbase, 0);

      // R1: strapped bit high
      addr_pin = 1'b1;
      i2c_start(); send_byte(8'hC0, ack); i2c_stop();
      chk(!ack, "R1 C0 refused with pin high", ack, 0);
      i2c_start(); send_byte(8'hC2, ack); i2c_stop();
      chk(ack, "R1 C2 taken with pin high", ack, 1);
      addr_pin = 1'b0;

      // R2: mismatched address followed by data
      base = wn;
      i2c_start(); send_byte(8'hA0, ack);
      chk(!ack, "R2 foreign address", ack, 0);
      send_byte(8'h05, ack); chk(!ack, "R2 later byte ignored", ack, 0);
      send_byte(8'h77, ack); chk(!ack, "R2 later byte ignored", ack, 0);
      i2c_stop();
      chk(wn == base, "R2 no store", wn - base, 0);

      // R3: single store at a volatile location, R8 no busy
      base = wn;
      i2c_start(); send_byte(8'hC0, ack); send_byte(8'h05, ack); send_byte(8'h5A, ack);
      chk(ack, "R3 data acked", ack, 1);
      i2c_stop(); shadow[8'h05] = 8'h5A; w(Q);
      chk(wn == base + 1, "R3 one store", wn - base, 1);
      chk(wl_addr[base] == 8'h05 && wl_data[base] == 8'h5A, "R3 store addr/data",
          {wl_addr[base], wl_data[base]}, 16'h055A);
      chk(!nv_busy, "R8 volatile write no busy", nv_busy, 0);

      // R4: row wrap sweep over every start offset, nine bytes each
      for (int off = 0; off < 8; off++) begin
         base = wn;
         i2c_start(); send_byte(8'hC0, ack); send_byte(8'(8'h60 + off), ack);
         for (int i = 0; i < 9; i++) begin
            send_byte(8'(off * 16 + i + 8'h11), ack);
            shadow[8'h60 | ((off + i) % 8)] = 8'(off * 16 + i + 8'h11);
         end
         i2c_stop(); w(Q);
         for (int i = 0; i < 9; i++)
            chk(wl_addr[base + i] == 8'(8'h60 | ((off + i) % 8)) &&
                wl_data[base + i] == 8'(off * 16 + i + 8'h11), "R4 row wrap address",
                wl_addr[base + i], 8'h60 | ((off + i) % 8));
         chk(!nv_busy, "R8 no busy outside window", nv_busy, 0);
      end

      // R5: current-address read (pointer is 60h after last sweep)
      rbase = rn;
      i2c_start(); send_byte(8'hC1, ack); recv_byte(1'b1, rb); i2c_stop();
      chk(ack && rb == shadow[8'h60], "R5 current address read", rb, shadow[8'h60]);
      chk(rn == rbase + 1, "R6 one fetch on nack", rn - rbase, 1);

      // R5/R6: pointer write, repeated START, four-byte read across a row end
      rbase = rn;
      i2c_start(); send_byte(8'hC0, ack); send_byte(8'h66, ack);
      i2c_start(); send_byte(8'hC1, ack);
      chk(ack, "R5 read address after restart", ack, 1);
      for (int i = 0; i < 4; i++) begin
         recv_byte(i == 3, rb);
         chk(rb == shadow[8'h66 + i], "R5 sequential read", rb, shadow[8'h66 + i]);
      end
      for (int i = 0; i < 40; i++) begin
         w(1);
         if (sda_oe) begin chk(0, "R6 released after nack", 1, 0); break; end
      end
      chk(rn == rbase + 4, "R6 fetch count", rn - rbase, 4);
      i2c_stop();

      // R8: nonvolatile store, polling
      base = wn;
      i2c_start(); send_byte(8'hC0, ack); send_byte(8'h12, ack); send_byte(8'hAB, ack);
      busy_len = 0;
      i2c_stop(); w(2);
      chk(nv_busy, "R8 busy after stop", nv_busy, 1);
      chk(wl_addr[base] == 8'h12 && wl_data[base] == 8'hAB, "R3 nv store",
          wl_addr[base], 8'h12);
      i2c_start(); send_byte(8'hC0, ack); i2c_stop();
      chk(!ack, "R8 address refused while busy", ack, 0);
      for (int i = 0; i < 2000 && nv_busy; i++) w(1);
      w(2);
      chk(busy_len == BUSY, "R8 busy length", busy_len, BUSY);
      i2c_start(); send_byte(8'hC0, ack); i2c_stop();
      chk(ack, "R8 address taken after busy", ack, 1);

      // R7: monitor result
      chk(viol == 0, "R7 sda moved while scl high", viol, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule